// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch-side status of every hardware thread in a multithreaded front end. Each cycle it weighs, per thread, the squash requests from the commit and decode stages, a flag saying the reorder buffer is still flushing, sticky stall flags set and cleared by block and unblock pulses from four downstream stages (decode, rename, issue/execute, commit), and a global context-switch stall. It then folds in the instruction-cache events for the thread: a line request issued this cycle, a rejection by the cache, a retry acceptance and a returning response.

Only one rejected request can wait for a retry at a time. While it waits, the cache counts as blocked for every thread and no thread may start a new line request. Responses whose tag no longer matches the thread's outstanding request, or which arrive after the thread has left the waiting state, are dropped. A stage-active output tells the pipeline whether any enabled thread still needs the fetch stage clocked.

Top module: `fetch_status_ctl`

## Requirements
- R1: After reset every thread is Running and the cache is not blocked. The 4-bit state codes are: Running=0, Idle=1, Squashing=2, Blocked=3, WaitResponse=4, WaitRetry=5, AccessComplete=6, TrapPending=7, QuiescePending=8. Thread t occupies bits [4t+3:4t] of `thr_state`.
- R2: Each of the four stages has a sticky stall flag per thread. `stall_set`/`stall_clr` bit s*NUM_THR+t addresses stage s (0 decode, 1 rename, 2 issue/execute, 3 commit) of thread t. A set pulse raises the flag and a clear pulse lowers it. When both arrive together, the clear wins. A thread with any raised flag, or with `ctx_stall` high, goes to Blocked unless it is in WaitResponse.
- R3: Per thread, the first matching rule applies: commit squash, then reorder-buffer flushing, then decode squash, then stall, then recovery. Each of the squash rules yields Squashing.
- R4: A decode squash has no effect on a thread that is already Squashing. Such a thread recovers to Running in the same cycle.
- R5: With no new event, a thread in Blocked or Squashing returns to Running, and a thread in AccessComplete moves to Running one cycle later.
- R6: `line_fire` is high when `req_valid` names an enabled thread that is Running after the rules above and the request is not suppressed. If `req_nack` is low, the thread moves to WaitResponse and `req_tag` becomes its outstanding tag.
- R7: A response is accepted only if the thread is in WaitResponse and `rsp_tag` equals its outstanding tag. Any other response is dropped. An accepted response moves the thread to Blocked if it is stalled, and to AccessComplete otherwise.
- R8: A fired request with `req_nack` high is parked in the single retry slot: the thread goes to WaitRetry and `cache_blocked` rises. `retry_ok` moves the parked thread to WaitResponse with the parked tag and clears both the slot and `cache_blocked`.
- R9: No request fires while `cache_blocked` is high, or while `irq_pending` is high and `priv_mode` is low.
- R10: A commit squash, or a decode squash that is not ignored, empties the retry slot and lowers `cache_blocked` if the parked request belongs to that thread. It also discards the thread's outstanding request, so a later response to it is dropped.
- R11: `stage_active` is high when any enabled thread is Running, Squashing or AccessComplete.
- R12: A thread whose `thread_active` bit is low keeps its state whatever squash or stall inputs arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active | input | NUM_THR | Enable per thread |
| stall_set | input | 4*NUM_THR | Block pulses, stage-major |
| stall_clr | input | 4*NUM_THR | Unblock pulses, stage-major |
| ctx_stall | input | 1 | Context-switch stall for all threads |
| cmt_squash | input | NUM_THR | Squash request from commit |
| rob_squashing | input | NUM_THR | Reorder buffer still flushing |
| dec_squash | input | NUM_THR | Squash request from decode |
| req_valid | input | 1 | A line request is offered |
| req_tid | input | TID_W | Thread of the offered request |
| req_tag | input | TAG_W | Tag of the offered request |
| req_nack | input | 1 | Cache rejects the request this cycle |
| irq_pending | input | 1 | Interrupt pending |
| priv_mode | input | 1 | Privileged mode; lets requests pass an interrupt |
| retry_ok | input | 1 | Cache accepts the parked request |
| rsp_valid | input | 1 | Cache response present |
| rsp_tid | input | TID_W | Thread of the response |
| rsp_tag | input | TAG_W | Tag of the response |
| line_fire | output | 1 | Request granted this cycle |
| thr_state | output | 4*NUM_THR | Packed state per thread |
| cache_blocked | output | 1 | Retry slot occupied |
| stage_active | output | 1 | Fetch stage has work |

## Verification
The colliding pair is a squash and a cache event aimed at the same thread in the same cycle. The bench raises a commit squash together with a matching response for a thread in WaitResponse, and separately together with `retry_ok` while that thread owns the retry slot. It then checks that the thread lands in Squashing, that `cache_blocked` falls, and that the same response repeated one cycle later is dropped. A decode squash paired with the global context stall also checks that the squash wins over the stall for that thread while the other thread blocks.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;

    localparam int NUM_STG = 4;
    localparam int ST_W    = 4;

    typedef enum logic [ST_W-1:0] {
        TS_RUN        = 4'd0,
        TS_IDLE       = 4'd1,
        TS_SQUASH     = 4'd2,
        TS_BLOCK      = 4'd3,
        TS_WAIT_RSP   = 4'd4,
        TS_WAIT_RETRY = 4'd5,
        TS_FILL_DONE  = 4'd6,
        TS_TRAP       = 4'd7,
        TS_QUIESCE    = 4'd8
    } thr_state_e;

    // Ordered resolution of the per-thread control signals.
    function automatic thr_state_e sig_step(
        input thr_state_e cur,
        input logic       cmt,
        input logic       rob,
        input logic       dec,
        input logic       stalled
    );
        if (cmt)                              return TS_SQUASH;
        if (rob)                              return TS_SQUASH;
        if (dec && cur != TS_SQUASH)          return TS_SQUASH;
        if (stalled && cur != TS_WAIT_RSP)    return TS_BLOCK;
        if (cur == TS_BLOCK || cur == TS_SQUASH) return TS_RUN;
        return cur;
    endfunction

endpackage

// File: rtl/fetch_stall_flags.sv
module fetch_stall_flags
    import fetch_ctl_pkg::*;
#(
    parameter int NUM_THR = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_STG*NUM_THR-1:0] stall_set,
    input  logic [NUM_STG*NUM_THR-1:0] stall_clr,
    output logic [NUM_THR-1:0]         stalled_nxt
);
    localparam int NFLAG = NUM_STG * NUM_THR;

    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_d;

    assign flag_d = (flag_q | stall_set) & ~stall_clr;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic [NUM_STG-1:0] per_stage;
        for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
            assign per_stage[s] = flag_d[s*NUM_THR + t];
        end
        assign stalled_nxt[t] = |per_stage;
    end
endmodule

// File: rtl/fetch_retry_slot.sv
module fetch_retry_slot #(
    parameter int NUM_THR = 2,
    parameter int TAG_W   = 4,
    parameter int TID_W   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               park,
    input  logic [TID_W-1:0]   park_tid,
    input  logic [TAG_W-1:0]   park_tag,
    input  logic [NUM_THR-1:0] squash_do,
    input  logic               retry_ok,
    output logic               slot_valid,
    output logic [TID_W-1:0]   slot_tid,
    output logic [TAG_W-1:0]   slot_tag,
    output logic               retry_fire
);
    logic owner_squashed;

    always_comb begin
        owner_squashed = 1'b0;
        for (int t = 0; t < NUM_THR; t++) begin
            if (slot_tid == TID_W'(t) && squash_do[t]) owner_squashed = 1'b1;
        end
    end

    assign retry_fire = retry_ok && slot_valid && !owner_squashed;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid <= 1'b0;
            slot_tid   <= '0;
            slot_tag   <= '0;
        end else if (park) begin
            slot_valid <= 1'b1;
            slot_tid   <= park_tid;
            slot_tag   <= park_tag;
        end else if (retry_fire || (slot_valid && owner_squashed)) begin
            slot_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/fetch_thread_fsm.sv
module fetch_thread_fsm
    import fetch_ctl_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  thr_state_e       post,
    input  logic             squash_do,
    input  logic             stalled,
    input  logic             fire,
    input  logic             nack,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             retry_hit,
    input  logic [TAG_W-1:0] retry_tag,
    input  logic             rsp_here,
    input  logic [TAG_W-1:0] rsp_tag,
    output thr_state_e       state_q
);
    thr_state_e       state_d;
    logic             ov_q, ov_d;
    logic [TAG_W-1:0] ot_q, ot_d;

    always_comb begin
        state_d = post;
        ov_d    = ov_q;
        ot_d    = ot_q;
        if (squash_do) ov_d = 1'b0;
        if (fire) begin
            state_d = nack ? TS_WAIT_RETRY : TS_WAIT_RSP;
            if (!nack) begin
                ov_d = 1'b1;
                ot_d = req_tag;
            end
        end else if (retry_hit) begin
            state_d = TS_WAIT_RSP;
            ov_d    = 1'b1;
            ot_d    = retry_tag;
        end else if (rsp_here && post == TS_WAIT_RSP && ov_q && rsp_tag == ot_q) begin
            state_d = stalled ? TS_BLOCK : TS_FILL_DONE;
            ov_d    = 1'b0;
        end else if (active && post == TS_FILL_DONE) begin
            state_d = TS_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_RUN;
            ov_q    <= 1'b0;
            ot_q    <= '0;
        end else begin
            state_q <= state_d;
            ov_q    <= ov_d;
            ot_q    <= ot_d;
        end
    end
endmodule

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl
    import fetch_ctl_pkg::*;
#(
    parameter int NUM_THR = 2,
    parameter int TAG_W   = 4,
    parameter int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_THR-1:0]         thread_active,
    input  logic [NUM_STG*NUM_THR-1:0] stall_set,
    input  logic [NUM_STG*NUM_THR-1:0] stall_clr,
    input  logic                       ctx_stall,
    input  logic [NUM_THR-1:0]         cmt_squash,
    input  logic [NUM_THR-1:0]         rob_squashing,
    input  logic [NUM_THR-1:0]         dec_squash,
    input  logic                       req_valid,
    input  logic [TID_W-1:0]           req_tid,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic                       req_nack,
    input  logic                       irq_pending,
    input  logic                       priv_mode,
    input  logic                       retry_ok,
    input  logic                       rsp_valid,
    input  logic [TID_W-1:0]           rsp_tid,
    input  logic [TAG_W-1:0]           rsp_tag,
    output logic                       line_fire,
    output logic [ST_W*NUM_THR-1:0]    thr_state,
    output logic                       cache_blocked,
    output logic                       stage_active
);
    logic [NUM_THR-1:0] stalled_nxt;
    logic [NUM_THR-1:0] squash_do;
    logic [NUM_THR-1:0] fire_vec;
    logic [NUM_THR-1:0] busy_vec;
    logic               req_hold;
    logic               slot_valid;
    logic [TID_W-1:0]   slot_tid;
    logic [TAG_W-1:0]   slot_tag;
    logic               retry_fire;

    assign req_hold = slot_valid || (irq_pending && !priv_mode);

    fetch_stall_flags #(.NUM_THR(NUM_THR)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .stall_set   (stall_set),
        .stall_clr   (stall_clr),
        .stalled_nxt (stalled_nxt)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        thr_state_e st_q;
        thr_state_e post;
        logic       stl;

        assign stl  = stalled_nxt[t] || ctx_stall;
        assign post = thread_active[t]
                    ? sig_step(st_q, cmt_squash[t], rob_squashing[t], dec_squash[t], stl)
                    : st_q;
        assign squash_do[t] = thread_active[t] &&
                              (cmt_squash[t] ||
                               (!rob_squashing[t] && dec_squash[t] && st_q != TS_SQUASH));
        assign fire_vec[t]  = req_valid && req_tid == TID_W'(t) && thread_active[t] &&
                              post == TS_RUN && !req_hold;
        assign busy_vec[t]  = thread_active[t] &&
                              (st_q == TS_RUN || st_q == TS_SQUASH || st_q == TS_FILL_DONE);
        assign thr_state[t*ST_W +: ST_W] = st_q;

        fetch_thread_fsm #(.TAG_W(TAG_W)) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .active    (thread_active[t]),
            .post      (post),
            .squash_do (squash_do[t]),
            .stalled   (stl),
            .fire      (fire_vec[t]),
            .nack      (req_nack),
            .req_tag   (req_tag),
            .retry_hit (retry_fire && slot_tid == TID_W'(t) && post == TS_WAIT_RETRY),
            .retry_tag (slot_tag),
            .rsp_here  (rsp_valid && rsp_tid == TID_W'(t)),
            .rsp_tag   (rsp_tag),
            .state_q   (st_q)
        );
    end

    assign line_fire     = |fire_vec;
    assign stage_active  = |busy_vec;
    assign cache_blocked = slot_valid;

    fetch_retry_slot #(.NUM_THR(NUM_THR), .TAG_W(TAG_W), .TID_W(TID_W)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .park       (line_fire && req_nack),
        .park_tid   (req_tid),
        .park_tag   (req_tag),
        .squash_do  (squash_do),
        .retry_ok   (retry_ok),
        .slot_valid (slot_valid),
        .slot_tid   (slot_tid),
        .slot_tag   (slot_tag),
        .retry_fire (retry_fire)
    );
endmodule

// File: rtl/fetch_status_chk.sv
module fetch_status_chk
    import fetch_ctl_pkg::*;
#(
    parameter int NUM_THR = 2,
    parameter int TAG_W   = 4,
    parameter int TID_W   = 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_THR-1:0]         thread_active,
    input logic [NUM_STG*NUM_THR-1:0] stall_set,
    input logic [NUM_STG*NUM_THR-1:0] stall_clr,
    input logic [NUM_THR-1:0]         cmt_squash,
    input logic [NUM_THR-1:0]         rob_squashing,
    input logic [NUM_THR-1:0]         dec_squash,
    input logic                       req_nack,
    input logic [TID_W-1:0]           req_tid,
    input logic                       irq_pending,
    input logic                       priv_mode,
    input logic                       rsp_valid,
    input logic [TID_W-1:0]           rsp_tid,
    input logic                       line_fire,
    input logic [ST_W*NUM_THR-1:0]    thr_state,
    input logic                       cache_blocked
);
    assert_fire_held_R9: assert property (@(posedge clk) disable iff (rst)
        line_fire |-> (!cache_blocked && !(irq_pending && !priv_mode)));

    assert_park_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (line_fire && req_nack) |=> cache_blocked);

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        assert_commit_squash_R3: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && cmt_squash[t])
            |=> thr_state[t*ST_W +: ST_W] == TS_SQUASH);

        assert_park_state_R8: assert property (@(posedge clk) disable iff (rst)
            (line_fire && req_nack && req_tid == TID_W'(t))
            |=> thr_state[t*ST_W +: ST_W] == TS_WAIT_RETRY);

        assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (rst)
            (thread_active[t] && !cmt_squash[t] && !rob_squashing[t] && !dec_squash[t] &&
             stall_set[t] && !stall_clr[t] &&
             thr_state[t*ST_W +: ST_W] != TS_WAIT_RSP)
            |=> thr_state[t*ST_W +: ST_W] == TS_BLOCK);

        assert_stale_rsp_R7: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid && rsp_tid == TID_W'(t) &&
             thr_state[t*ST_W +: ST_W] != TS_WAIT_RSP)
            |=> thr_state[t*ST_W +: ST_W] != TS_FILL_DONE);

        assert_inactive_hold_R12: assert property (@(posedge clk) disable iff (rst)
            !thread_active[t] |=> $stable(thr_state[t*ST_W +: ST_W]));
    end
endmodule

bind fetch_status_ctl fetch_status_chk #(
    .NUM_THR(NUM_THR), .TAG_W(TAG_W), .TID_W(TID_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .thread_active (thread_active),
    .stall_set     (stall_set),
    .stall_clr     (stall_clr),
    .cmt_squash    (cmt_squash),
    .rob_squashing (rob_squashing),
    .dec_squash    (dec_squash),
    .req_nack      (req_nack),
    .req_tid       (req_tid),
    .irq_pending   (irq_pending),
    .priv_mode     (priv_mode),
    .rsp_valid     (rsp_valid),
    .rsp_tid       (rsp_tid),
    .line_fire     (line_fire),
    .thr_state     (thr_state),
    .cache_blocked (cache_blocked)
);

// File: tb/tb_fetch_status_ctl.sv
`timescale 1ns/1ps
module tb_fetch_status_ctl;
    localparam int NT = 2;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NT-1:0] thread_active;
    logic [4*NT-1:0] stall_set, stall_clr;
    logic          ctx_stall;
    logic [NT-1:0] cmt_squash, rob_squashing, dec_squash;
    logic          req_valid, req_nack, irq_pending, priv_mode, retry_ok, rsp_valid;
    logic          req_tid, rsp_tid;
    logic [TW-1:0] req_tag, rsp_tag;
    logic          line_fire, cache_blocked, stage_active;
    logic [4*NT-1:0] thr_state;

    always #10 clk = ~clk;

    fetch_status_ctl #(.NUM_THR(NT), .TAG_W(TW)) dut (
        .clk(clk), .rst(rst), .thread_active(thread_active),
        .stall_set(stall_set), .stall_clr(stall_clr), .ctx_stall(ctx_stall),
        .cmt_squash(cmt_squash), .rob_squashing(rob_squashing), .dec_squash(dec_squash),
        .req_valid(req_valid), .req_tid(req_tid), .req_tag(req_tag), .req_nack(req_nack),
        .irq_pending(irq_pending), .priv_mode(priv_mode), .retry_ok(retry_ok),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_tag(rsp_tag),
        .line_fire(line_fire), .thr_state(thr_state),
        .cache_blocked(cache_blocked), .stage_active(stage_active)
    );

    typedef struct {
        string    req;
        logic [7:0] st;
        logic     cb;
        logic     sa;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        stall_set = '0; stall_clr = '0; ctx_stall = 0;
        cmt_squash = '0; rob_squashing = '0; dec_squash = '0;
        req_valid = 0; req_tid = 0; req_tag = '0; req_nack = 0;
        irq_pending = 0; priv_mode = 0; retry_ok = 0;
        rsp_valid = 0; rsp_tid = 0; rsp_tag = '0;
    endtask

    task automatic begin_step();
        @(negedge clk);
        #1;
        clear_in();
    endtask

    // Check the combinational grant, then queue the state expected after the edge.
    task automatic end_step(string req, logic efire, logic [7:0] est, logic ecb, logic esa);
        exp_t it;
        #2;
        check_bit(req, "line_fire", line_fire, efire);
        it.req = req; it.st = est; it.cb = ecb; it.sa = esa;
        sb_q.push_back(it);
    endtask

    // Monitor: one expected item per cycle, sampled mid-low-phase.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (thr_state !== it.st) begin
                    n_fail++;
                    $display("FAIL %s thr_state act=%h exp=%h", it.req, thr_state, it.st);
                end
                check_bit(it.req, "cache_blocked", cache_blocked, it.cb);
                check_bit(it.req, "stage_active", stage_active, it.sa);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_in();
        thread_active = 2'b11;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (thr_state !== 8'h00) begin
            n_fail++;
            $display("FAIL R1 thr_state act=%h exp=%h", thr_state, 8'h00);
        end
        check_bit("R1", "cache_blocked", cache_blocked, 1'b0);

        begin_step(); end_step("R1", 0, 8'h00, 0, 1);
        // R6: thread 0 request accepted -> WaitResponse
        begin_step(); req_valid = 1; req_tid = 0; req_tag = 4'd3;
        end_step("R6", 1, 8'h04, 0, 1);
        // R7: wrong tag dropped
        begin_step(); rsp_valid = 1; rsp_tid = 0; rsp_tag = 4'd5;
        end_step("R7", 0, 8'h04, 0, 1);
        // R7: matching tag -> AccessComplete
        begin_step(); rsp_valid = 1; rsp_tid = 0; rsp_tag = 4'd3;
        end_step("R7", 0, 8'h06, 0, 1);
        // R5: AccessComplete -> Running
        begin_step(); end_step("R5", 0, 8'h00, 0, 1);
        // R2: decode block on thread 1 (bit 0*2+1)
        begin_step(); stall_set[1] = 1;
        end_step("R2", 0, 8'h30, 0, 1);
        begin_step(); end_step("R2", 0, 8'h30, 0, 1);
        begin_step(); stall_clr[1] = 1;
        end_step("R5", 0, 8'h00, 0, 1);
        // R8: thread 1 request rejected -> WaitRetry, cache blocked
        begin_step(); req_valid = 1; req_tid = 1; req_tag = 4'd7; req_nack = 1;
        end_step("R8", 1, 8'h50, 1, 1);
        // R9: request suppressed while cache blocked
        begin_step(); req_valid = 1; req_tid = 0; req_tag = 4'd2;
        end_step("R9", 0, 8'h50, 1, 1);
        // R8: retry accepted -> WaitResponse, slot cleared
        begin_step(); retry_ok = 1;
        end_step("R8", 0, 8'h40, 0, 1);
        // R10: commit squash and matching response together: squash wins
        begin_step(); cmt_squash = 2'b10; rsp_valid = 1; rsp_tid = 1; rsp_tag = 4'd7;
        end_step("R10", 0, 8'h20, 0, 1);
        // R10: repeated response is stale, thread recovers
        begin_step(); rsp_valid = 1; rsp_tid = 1; rsp_tag = 4'd7;
        end_step("R10", 0, 8'h00, 0, 1);
        // R8: thread 0 parked
        begin_step(); req_valid = 1; req_tid = 0; req_tag = 4'd1; req_nack = 1;
        end_step("R8", 1, 8'h05, 1, 1);
        // R10: squash of owner with retry in same cycle clears slot
        begin_step(); cmt_squash = 2'b01; retry_ok = 1;
        end_step("R10", 0, 8'h02, 0, 1);
        begin_step(); end_step("R5", 0, 8'h00, 0, 1);
        // R3: flush flag with decode squash -> Squashing
        begin_step(); rob_squashing = 2'b01; dec_squash = 2'b01;
        end_step("R3", 0, 8'h02, 0, 1);
        // R4: decode squash while Squashing is ignored, thread recovers
        begin_step(); dec_squash = 2'b01;
        end_step("R4", 0, 8'h00, 0, 1);
        // R3: decode squash beats context stall on thread 1; thread 0 blocks
        begin_step(); dec_squash = 2'b10; ctx_stall = 1;
        end_step("R3", 0, 8'h23, 0, 1);
        // R11: both blocked -> stage idle
        begin_step(); ctx_stall = 1;
        end_step("R11", 0, 8'h33, 0, 0);
        begin_step(); end_step("R5", 0, 8'h00, 0, 1);
        // R9: interrupt pending outside privileged mode holds the request
        begin_step(); irq_pending = 1; req_valid = 1; req_tid = 0; req_tag = 4'd9;
        end_step("R9", 0, 8'h00, 0, 1);
        // R9: privileged mode lets it pass
        begin_step(); irq_pending = 1; priv_mode = 1; req_valid = 1; req_tid = 0; req_tag = 4'd9;
        end_step("R6", 1, 8'h04, 0, 1);
        // R2: issue/execute block (bit 2*2+0) does not move WaitResponse
        begin_step(); stall_set[4] = 1;
        end_step("R2", 0, 8'h04, 0, 1);
        // R7: accepted response while stalled -> Blocked
        begin_step(); rsp_valid = 1; rsp_tid = 0; rsp_tag = 4'd9;
        end_step("R7", 0, 8'h03, 0, 1);
        begin_step(); stall_clr[4] = 1;
        end_step("R2", 0, 8'h00, 0, 1);
        // R12 / R11: disabled threads ignore a squash and stage goes idle
        begin_step(); thread_active = 2'b00; cmt_squash = 2'b01;
        end_step("R12", 0, 8'h00, 0, 0);
        begin_step(); thread_active = 2'b11;
        end_step("R11", 0, 8'h00, 0, 1);

        begin_step();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule